// File: doc/BRIEF.md
# Firmware-Update Command Sequencer

This block runs the control state machine behind a firmware-update channel. A control front end hands it one decoded command at a time: a 7-bit command number, a read/write flag and a 16-bit argument taken from the leading payload bytes. The block returns a status byte and up to five response bytes. It tracks the update state, the selected image (factory or upgrade), the next download block and a transfer-block register used for uploads. Block transfers go to an external flash agent through a one-cycle request pulse and a done pulse. Detach and reboot commands raise a reboot request that the chip's reset logic acts on.

Image data sits in a 128-byte staging buffer. The host writes download data into it before a download command. The flash agent fills it before completing an upload. A single read port serves both the host and the flash agent. The buffer keeps a valid-length register, and reads past that length return zero, which gives short upload frames their padding. Clearing the buffer only resets the length, so the storage maps onto a plain block RAM.

Only one command is in flight at a time. Uploads hold off the response and keep the command channel closed until the flash agent completes. Downloads answer at once and let the host poll the status for a busy timeout.

Top module: `fwup_ctrl`

## Requirements
- R1: After reset `cmd_ready` is 1, the state number is 2 (idle) and the transfer-block register is 0. Every accepted command except a legal upload raises `rsp_valid` for one cycle, in the cycle after the acceptance edge.
- R2: Command 0 (detach) and command 89 (reboot) set `reboot_req`. It stays high until reset. The argument is ignored and the state does not change.
- R3: Command 64 with argument 0 or 1 selects the factory or upgrade image (driven on `fl_alt`), forces state 2, clears the status code and empties the buffer, so every buffer read returns 0. It leaves the transfer-block register unchanged. An argument above 1 is illegal.
- R4: Command 1 with a length of 1 to 128, issued in state 2 or 5 with no write pending, sends a flash write request (`fl_write`=1) carrying the length. Block numbers start at 0 and count up by one per request. The state moves to 3. A length above 128 is illegal.
- R5: Command 3 returns bytes in this order: status code (byte 0), a 24-bit little-endian poll timeout (bytes 1 to 3), and the next state (byte 4). In state 3 or 4 with the flash write unfinished, the timeout is POLL_MS and the next state is 4. Once the write is done, the timeout is 0 and the next state is 5. The machine moves to the reported next state.
- R6: Command 1 with length 0 in state 5 moves to state 6. A status query in state 6 reports next state 2 and returns to idle, and the download block count restarts at 0. Length 0 in state 2 is illegal.
- R7: Command 2 in state 2 or 9 sends a flash read request for the current transfer block and the selected image. `cmd_ready` stays low until `fl_done`. The response, in bytes 0 and 1 little-endian, carries `fl_rlen`, and buffer reads at or beyond that length return 0.
- R8: Each serviced upload adds one to the transfer-block register. A frame of 128 bytes moves to state 9. A shorter frame ends the upload: the state goes to 2 and the register goes to 0.
- R9: Command 65 with the read flag returns the 16-bit transfer block in bytes 0 and 1. With the write flag it loads the argument. Abort does not clear it.
- R10: Command 6 in state 2, 5 or 9 returns to state 2.
- R11: An illegal command (unknown number, wrong state or bad argument) gets response status 1 and moves to state 10 with status code 0x0F. Command 4 in state 10 returns to state 2 with status code 0. Command 4 outside state 10 is illegal.
- R12: Command 88 returns major, minor and patch version bytes in bytes 0, 1 and 2.
- R13: Command 5 returns the current state number in byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_id | input | 7 | Command number |
| cmd_rd | input | 1 | 1 = read form of the command |
| cmd_arg | input | 16 | Leading payload bytes, little-endian |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_status | output | 8 | 0 = accepted, 1 = rejected |
| rsp_data | output | 40 | Response bytes, byte 0 in bits 7:0 |
| hbuf_we | input | 1 | Host buffer write enable |
| hbuf_addr | input | 7 | Host buffer write address |
| hbuf_wdata | input | 8 | Host buffer write data |
| buf_raddr | input | 7 | Buffer read address |
| buf_rdata | output | 8 | Buffer read data, one cycle after the address |
| fl_req | output | 1 | Flash request pulse |
| fl_write | output | 1 | 1 = write block, 0 = read block |
| fl_alt | output | 1 | Selected image |
| fl_block | output | 16 | Block number of the request |
| fl_len | output | 8 | Byte count of a write request |
| fl_done | input | 1 | Flash operation finished (pulse) |
| fl_rlen | input | 8 | Bytes produced by a read |
| fl_we | input | 1 | Flash-side buffer write enable |
| fl_waddr | input | 7 | Flash-side buffer write address |
| fl_wdata | input | 8 | Flash-side buffer write data |
| reboot_req | output | 1 | Reboot request, held until reset |

## Verification
On every cycle, the checker confirms that the state register only holds one of the seven defined state numbers. It also confirms that the error state always carries a nonzero status code, that the reboot request never drops once raised, and that flash requests are single pulses. Two more per-cycle checks cover the command channel: it stays closed whenever an upload request is out, and a response only follows an accepted command or a flash completion. The bench's scenarios are needed for the protocol itself: the busy timeout before a flash write completes and the next-state handover after it, the block numbering across downloads and uploads, the short-frame ending, the survival of the transfer block through abort and image selection, and the zero padding of buffer reads.

// File: rtl/fwup_pkg.sv
package fwup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd2,
    ST_DNSYNC = 4'd3,
    ST_DNBUSY = 4'd4,
    ST_DNIDLE = 4'd5,
    ST_MANSYN = 4'd6,
    ST_UPIDLE = 4'd9,
    ST_ERROR  = 4'd10
  } dfu_st_e;

  localparam logic [6:0] CMD_DETACH  = 7'd0;
  localparam logic [6:0] CMD_DNLOAD  = 7'd1;
  localparam logic [6:0] CMD_UPLOAD  = 7'd2;
  localparam logic [6:0] CMD_GETSTAT = 7'd3;
  localparam logic [6:0] CMD_CLRSTAT = 7'd4;
  localparam logic [6:0] CMD_GETST   = 7'd5;
  localparam logic [6:0] CMD_ABORT   = 7'd6;
  localparam logic [6:0] CMD_SETALT  = 7'd64;
  localparam logic [6:0] CMD_XFERBLK = 7'd65;
  localparam logic [6:0] CMD_VERSION = 7'd88;
  localparam logic [6:0] CMD_REBOOT  = 7'd89;

  localparam logic [7:0] STAT_OK    = 8'h00;
  localparam logic [7:0] STAT_STALL = 8'h0F;

  localparam logic [7:0] RSP_OK     = 8'd0;
  localparam logic [7:0] RSP_REJECT = 8'd1;

endpackage

// File: rtl/fwup_imgbuf.sv
module fwup_imgbuf #(
  parameter int BYTES = 128,
  parameter int AW    = $clog2(BYTES),
  parameter int LW    = $clog2(BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  input  logic          len_clr,
  input  logic          len_set,
  input  logic [LW-1:0] len_val
);

  logic [7:0]    mem [BYTES];
  logic [7:0]    mem_q;
  logic [AW-1:0] raddr_q;
  logic [LW-1:0] len_q;

  // storage without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    mem_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raddr_q <= '0;
      len_q   <= '0;
    end else begin
      raddr_q <= raddr;
      if (len_clr)      len_q <= '0;
      else if (len_set) len_q <= len_val;
    end
  end

  // bytes beyond the valid length read as padding
  assign rdata = (LW'(raddr_q) < len_q) ? mem_q : 8'd0;

endmodule

// File: rtl/fwup_seq.sv
module fwup_seq
  import fwup_pkg::*;
#(
  parameter int          BYTES   = 128,
  parameter int          LW      = $clog2(BYTES + 1),
  parameter int          BLK_W   = 16,
  parameter logic [23:0] POLL_MS = 24'd5,
  parameter logic [7:0]  VER_MAJ = 8'd1,
  parameter logic [7:0]  VER_MIN = 8'd2,
  parameter logic [7:0]  VER_PAT = 8'd3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [6:0]       cmd_id,
  input  logic             cmd_rd,
  input  logic [15:0]      cmd_arg,
  output logic             rsp_valid,
  output logic [7:0]       rsp_status,
  output logic [39:0]      rsp_data,
  output logic             fl_req,
  output logic             fl_write,
  output logic             fl_alt,
  output logic [BLK_W-1:0] fl_block,
  output logic [LW-1:0]    fl_len,
  input  logic             fl_done,
  input  logic [LW-1:0]    fl_rlen,
  output logic             len_clr,
  output logic             len_set,
  output logic [LW-1:0]    len_val,
  output logic             reboot_req,
  output dfu_st_e          st,
  output logic [7:0]       stat
);

  logic [BLK_W-1:0] xfer_blk, dn_blk;
  logic             up_wait, wr_pend;
  logic             accept, legal;
  dfu_st_e          gs_next;
  logic [23:0]      gs_tmo;

  assign cmd_ready = !up_wait;
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    case (cmd_id)
      CMD_DETACH, CMD_REBOOT, CMD_GETSTAT, CMD_GETST,
      CMD_XFERBLK, CMD_VERSION: legal = 1'b1;
      CMD_SETALT:  legal = (cmd_arg[7:0] <= 8'd1);
      CMD_DNLOAD:
        if (cmd_arg == 16'd0) legal = (st == ST_DNIDLE);
        else legal = (st == ST_IDLE || st == ST_DNIDLE) && !wr_pend &&
                     (cmd_arg <= 16'(BYTES));
      CMD_UPLOAD:  legal = (st == ST_IDLE || st == ST_UPIDLE);
      CMD_CLRSTAT: legal = (st == ST_ERROR);
      CMD_ABORT:   legal = (st == ST_IDLE || st == ST_DNIDLE || st == ST_UPIDLE);
      default:     legal = 1'b0;
    endcase
  end

  // status poll: next state and timeout
  always_comb begin
    gs_next = st;
    gs_tmo  = 24'd0;
    if (st == ST_DNSYNC || st == ST_DNBUSY) begin
      gs_next = wr_pend ? ST_DNBUSY : ST_DNIDLE;
      gs_tmo  = wr_pend ? POLL_MS : 24'd0;
    end else if (st == ST_MANSYN) begin
      gs_next = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      stat       <= STAT_OK;
      xfer_blk   <= '0;
      dn_blk     <= '0;
      up_wait    <= 1'b0;
      wr_pend    <= 1'b0;
      fl_alt     <= 1'b0;
      reboot_req <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_status <= RSP_OK;
      rsp_data   <= '0;
      fl_req     <= 1'b0;
      fl_write   <= 1'b0;
      fl_block   <= '0;
      fl_len     <= '0;
      len_clr    <= 1'b0;
      len_set    <= 1'b0;
      len_val    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      fl_req    <= 1'b0;
      len_clr   <= 1'b0;
      len_set   <= 1'b0;

      if (fl_done) begin
        if (up_wait) begin
          up_wait    <= 1'b0;
          rsp_valid  <= 1'b1;
          rsp_status <= RSP_OK;
          rsp_data   <= {{(40-LW){1'b0}}, fl_rlen};
          len_set    <= 1'b1;
          len_val    <= fl_rlen;
          if (fl_rlen < LW'(BYTES)) begin
            st       <= ST_IDLE;
            xfer_blk <= '0;
            dn_blk   <= '0;
          end else begin
            st       <= ST_UPIDLE;
            xfer_blk <= xfer_blk + 1'b1;
          end
        end else begin
          wr_pend <= 1'b0;
        end
      end

      if (accept) begin
        rsp_valid  <= !(legal && cmd_id == CMD_UPLOAD);
        rsp_status <= legal ? RSP_OK : RSP_REJECT;
        rsp_data   <= '0;
        if (!legal) begin
          st     <= ST_ERROR;
          stat   <= STAT_STALL;
          dn_blk <= '0;
        end else begin
          case (cmd_id)
            CMD_DETACH, CMD_REBOOT: reboot_req <= 1'b1;
            CMD_GETSTAT: begin
              rsp_data <= {4'd0, gs_next, gs_tmo, stat};
              st       <= gs_next;
              if (gs_next == ST_IDLE) dn_blk <= '0;
            end
            CMD_GETST:   rsp_data <= {36'd0, st};
            CMD_CLRSTAT: begin
              st     <= ST_IDLE;
              stat   <= STAT_OK;
              dn_blk <= '0;
            end
            CMD_ABORT: begin
              st     <= ST_IDLE;
              dn_blk <= '0;
            end
            CMD_SETALT: begin
              fl_alt  <= cmd_arg[0];
              st      <= ST_IDLE;
              stat    <= STAT_OK;
              len_clr <= 1'b1;
              dn_blk  <= '0;
            end
            CMD_XFERBLK: begin
              if (cmd_rd) rsp_data <= {{(40-BLK_W){1'b0}}, xfer_blk};
              else        xfer_blk <= cmd_arg[BLK_W-1:0];
            end
            CMD_VERSION: rsp_data <= {16'd0, VER_PAT, VER_MIN, VER_MAJ};
            CMD_DNLOAD: begin
              if (cmd_arg == 16'd0) begin
                st <= ST_MANSYN;
              end else begin
                fl_req   <= 1'b1;
                fl_write <= 1'b1;
                fl_block <= dn_blk;
                fl_len   <= cmd_arg[LW-1:0];
                dn_blk   <= dn_blk + 1'b1;
                wr_pend  <= 1'b1;
                len_set  <= 1'b1;
                len_val  <= cmd_arg[LW-1:0];
                st       <= ST_DNSYNC;
              end
            end
            CMD_UPLOAD: begin
              fl_req   <= 1'b1;
              fl_write <= 1'b0;
              fl_block <= xfer_blk;
              fl_len   <= LW'(BYTES);
              up_wait  <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/fwup_ctrl.sv
module fwup_ctrl
  import fwup_pkg::*;
#(
  parameter int          BYTES   = 128,
  parameter int          BLK_W   = 16,
  parameter logic [23:0] POLL_MS = 24'd5,
  parameter logic [7:0]  VER_MAJ = 8'd1,
  parameter logic [7:0]  VER_MIN = 8'd2,
  parameter logic [7:0]  VER_PAT = 8'd3,
  localparam int         AW      = $clog2(BYTES),
  localparam int         LW      = $clog2(BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [6:0]       cmd_id,
  input  logic             cmd_rd,
  input  logic [15:0]      cmd_arg,
  output logic             rsp_valid,
  output logic [7:0]       rsp_status,
  output logic [39:0]      rsp_data,
  input  logic             hbuf_we,
  input  logic [AW-1:0]    hbuf_addr,
  input  logic [7:0]       hbuf_wdata,
  input  logic [AW-1:0]    buf_raddr,
  output logic [7:0]       buf_rdata,
  output logic             fl_req,
  output logic             fl_write,
  output logic             fl_alt,
  output logic [BLK_W-1:0] fl_block,
  output logic [LW-1:0]    fl_len,
  input  logic             fl_done,
  input  logic [LW-1:0]    fl_rlen,
  input  logic             fl_we,
  input  logic [AW-1:0]    fl_waddr,
  input  logic [7:0]       fl_wdata,
  output logic             reboot_req
);

  logic          len_clr, len_set;
  logic [LW-1:0] len_val;
  dfu_st_e       dfu_st;
  logic [7:0]    dfu_stat;

  // flash fills and host staging never overlap; flash side wins
  logic          b_we;
  logic [AW-1:0] b_waddr;
  logic [7:0]    b_wdata;
  assign b_we    = fl_we || hbuf_we;
  assign b_waddr = fl_we ? fl_waddr : hbuf_addr;
  assign b_wdata = fl_we ? fl_wdata : hbuf_wdata;

  fwup_imgbuf #(.BYTES(BYTES), .AW(AW), .LW(LW)) u_buf (
    .clk(clk), .rst(rst),
    .we(b_we), .waddr(b_waddr), .wdata(b_wdata),
    .raddr(buf_raddr), .rdata(buf_rdata),
    .len_clr(len_clr), .len_set(len_set), .len_val(len_val)
  );

  fwup_seq #(
    .BYTES(BYTES), .LW(LW), .BLK_W(BLK_W), .POLL_MS(POLL_MS),
    .VER_MAJ(VER_MAJ), .VER_MIN(VER_MIN), .VER_PAT(VER_PAT)
  ) u_seq (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_id(cmd_id),
    .cmd_rd(cmd_rd), .cmd_arg(cmd_arg),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
    .fl_req(fl_req), .fl_write(fl_write), .fl_alt(fl_alt),
    .fl_block(fl_block), .fl_len(fl_len), .fl_done(fl_done), .fl_rlen(fl_rlen),
    .len_clr(len_clr), .len_set(len_set), .len_val(len_val),
    .reboot_req(reboot_req), .st(dfu_st), .stat(dfu_stat)
  );

endmodule

// File: rtl/fwup_ctrl_chk.sv
module fwup_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       rsp_valid,
  input logic       fl_req,
  input logic       fl_write,
  input logic       fl_done,
  input logic       reboot_req,
  input logic [3:0] dfu_st,
  input logic [7:0] dfu_stat
);

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (rst)
    dfu_st inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd9, 4'd10});

  assert_rsp_cause_R1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(cmd_valid && cmd_ready) || $past(fl_done)));

  assert_reboot_hold_R2: assert property (@(posedge clk) disable iff (rst)
    reboot_req |=> reboot_req);

  assert_req_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    fl_req |=> !fl_req);

  assert_upload_closed_R7: assert property (@(posedge clk) disable iff (rst)
    (fl_req && !fl_write) |-> !cmd_ready);

  assert_err_code_R11: assert property (@(posedge clk) disable iff (rst)
    (dfu_st == 4'd10) |-> (dfu_stat != 8'd0));

endmodule

bind fwup_ctrl fwup_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .fl_req(fl_req), .fl_write(fl_write),
  .fl_done(fl_done), .reboot_req(reboot_req),
  .dfu_st(dfu_st), .dfu_stat(dfu_stat)
);

// File: tb/fwup_ctrl_test.sv
module fwup_ctrl_test;

  logic        clk = 0;
  logic        rst = 1;
  logic        cmd_valid = 0, cmd_rd = 0;
  logic [6:0]  cmd_id = 0;
  logic [15:0] cmd_arg = 0;
  logic        cmd_ready, rsp_valid;
  logic [7:0]  rsp_status;
  logic [39:0] rsp_data;
  logic        hbuf_we = 0;
  logic [6:0]  hbuf_addr = 0, buf_raddr = 0;
  logic [7:0]  hbuf_wdata = 0, buf_rdata;
  logic        fl_req, fl_write, fl_alt, reboot_req;
  logic [15:0] fl_block;
  logic [7:0]  fl_len;
  logic        fl_done = 0, fl_we = 0;
  logic [7:0]  fl_rlen = 0, fl_wdata = 0;
  logic [6:0]  fl_waddr = 0;

  int n_tests = 0, n_fail = 0;
  int wdly = 20, up_rlen = 128;
  int fr_cnt = 0;
  logic        fr_write, fr_alt;
  logic [15:0] fr_block;
  logic [7:0]  fr_len;

  logic [7:0]  q_st[$];
  logic [39:0] q_d[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  fwup_ctrl uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_id(cmd_id), .cmd_rd(cmd_rd), .cmd_arg(cmd_arg),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
    .hbuf_we(hbuf_we), .hbuf_addr(hbuf_addr), .hbuf_wdata(hbuf_wdata),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .fl_req(fl_req), .fl_write(fl_write), .fl_alt(fl_alt),
    .fl_block(fl_block), .fl_len(fl_len), .fl_done(fl_done), .fl_rlen(fl_rlen),
    .fl_we(fl_we), .fl_waddr(fl_waddr), .fl_wdata(fl_wdata),
    .reboot_req(reboot_req)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: issue a command and queue the expected response
  task automatic send(input logic [6:0] id, input logic rd, input logic [15:0] arg,
                      input logic [7:0] est, input logic [39:0] ed, input string tag);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_id = id; cmd_rd = rd; cmd_arg = arg;
    q_st.push_back(est); q_d.push_back(ed); q_tag.push_back(tag);
    @(negedge clk);
    cmd_valid = 0;
    while (q_st.size() != 0) @(negedge clk);
  endtask

  // monitor: compare responses against the scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q_st.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R1 unexpected response: actual %0h expected none", rsp_data);
      end else begin
        check({q_tag[0], " status"}, 64'(rsp_status), 64'(q_st[0]));
        check({q_tag[0], " data"}, 64'(rsp_data), 64'(q_d[0]));
        void'(q_st.pop_front()); void'(q_d.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  // flash agent model
  initial begin
    forever begin
      @(negedge clk);
      if (fl_req) begin
        fr_cnt++; fr_write = fl_write; fr_block = fl_block;
        fr_alt = fl_alt; fr_len = fl_len;
        if (fl_write) begin
          repeat (wdly) @(negedge clk);
          fl_done = 1; @(negedge clk); fl_done = 0;
        end else begin
          for (int i = 0; i < up_rlen; i++) begin
            fl_we = 1; fl_waddr = 7'(i); fl_wdata = 8'(fr_block * 16 + i);
            if (i == 10) check("R7 channel closed during upload", 64'(cmd_ready), 64'd0);
            @(negedge clk);
          end
          fl_we = 0; fl_rlen = 8'(up_rlen); fl_done = 1;
          @(negedge clk); fl_done = 0;
        end
      end
    end
  end

  task automatic rdbuf(input logic [6:0] a, input logic [7:0] e, input string tag);
    buf_raddr = a;
    @(negedge clk);
    check(tag, 64'(buf_rdata), 64'(e));
  endtask

  task automatic hwrite(input logic [6:0] a, input logic [7:0] d);
    hbuf_we = 1; hbuf_addr = a; hbuf_wdata = d;
    @(negedge clk);
    hbuf_we = 0;
  endtask

  task automatic do_reset;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int c0;
    do_reset();
    // R1 reset state
    check("R1 ready after reset", 64'(cmd_ready), 64'd1);
    check("R2 no reboot after reset", 64'(reboot_req), 64'd0);
    send(7'd5, 1, 0, 8'd0, 40'd2, "R1 R13 getstate idle");
    send(7'd65, 1, 0, 8'd0, 40'd0, "R1 R9 transfer block zero");
    send(7'd88, 1, 0, 8'd0, 40'h0000030201, "R12 version");
    send(7'd3, 1, 0, 8'd0, 40'h0200000000, "R5 status idle");

    // download path R4 R5
    for (int i = 0; i < 10; i++) hwrite(7'(i), 8'(8'h50 + i));
    c0 = fr_cnt;
    send(7'd1, 0, 16'd10, 8'd0, 40'd0, "R4 dnload 10");
    check("R4 write request count", 64'(fr_cnt - c0), 64'd1);
    check("R4 write flag", 64'(fr_write), 64'd1);
    check("R4 first block", 64'(fr_block), 64'd0);
    check("R4 length", 64'(fr_len), 64'd10);
    send(7'd3, 1, 0, 8'd0, 40'h0400000500, "R5 status busy");
    send(7'd5, 1, 0, 8'd0, 40'd4, "R5 state dnbusy");
    repeat (30) @(negedge clk);
    send(7'd3, 1, 0, 8'd0, 40'h0500000000, "R5 status done");
    send(7'd5, 1, 0, 8'd0, 40'd5, "R5 state dnidle");
    send(7'd1, 0, 16'd128, 8'd0, 40'd0, "R4 dnload 128");
    check("R4 second block", 64'(fr_block), 64'd1);
    repeat (30) @(negedge clk);
    send(7'd3, 1, 0, 8'd0, 40'h0500000000, "R5 status done 2");
    send(7'd1, 0, 16'd200, 8'd1, 40'd0, "R4 R11 oversize rejected");
    send(7'd3, 1, 0, 8'd0, 40'h0A0000000F, "R11 status in error");
    send(7'd4, 0, 0, 8'd0, 40'd0, "R11 clrstatus");
    send(7'd5, 1, 0, 8'd0, 40'd2, "R11 state after clear");

    // restart and manifest R6
    for (int i = 0; i < 4; i++) hwrite(7'(i), 8'(8'hA0 + i));
    send(7'd1, 0, 16'd4, 8'd0, 40'd0, "R6 dnload restart");
    check("R6 block restarts at 0", 64'(fr_block), 64'd0);
    repeat (30) @(negedge clk);
    send(7'd3, 1, 0, 8'd0, 40'h0500000000, "R6 status done");
    send(7'd1, 0, 16'd0, 8'd0, 40'd0, "R6 zero length ends");
    send(7'd5, 1, 0, 8'd0, 40'd6, "R6 manifest sync");
    send(7'd3, 1, 0, 8'd0, 40'h0200000000, "R6 status manifest");
    send(7'd5, 1, 0, 8'd0, 40'd2, "R6 back to idle");
    rdbuf(7'd1, 8'hA1, "R4 buffer holds download byte");
    rdbuf(7'd5, 8'h00, "R7 buffer past length pads");
    send(7'd1, 0, 16'd0, 8'd1, 40'd0, "R6 zero length in idle rejected");
    send(7'd4, 0, 0, 8'd0, 40'd0, "R11 clear");
    send(7'd4, 0, 0, 8'd1, 40'd0, "R11 clrstatus outside error");
    send(7'd4, 0, 0, 8'd0, 40'd0, "R11 clear 2");
    send(7'd7, 0, 0, 8'd1, 40'd0, "R11 unknown command");
    send(7'd5, 1, 0, 8'd0, 40'd10, "R11 state error");
    send(7'd64, 0, 16'd1, 8'd0, 40'd0, "R3 select upgrade");
    send(7'd3, 1, 0, 8'd0, 40'h0200000000, "R3 status cleared");
    rdbuf(7'd1, 8'h00, "R3 buffer emptied");

    // upload R7 R8 R9 R10
    up_rlen = 128;
    send(7'd2, 1, 0, 8'd0, 40'd128, "R7 upload full");
    check("R7 read request", 64'(fr_write), 64'd0);
    check("R7 upload block", 64'(fr_block), 64'd0);
    check("R3 image select driven", 64'(fr_alt), 64'd1);
    send(7'd5, 1, 0, 8'd0, 40'd9, "R8 state upidle");
    send(7'd65, 1, 0, 8'd0, 40'd1, "R8 block incremented");
    rdbuf(7'd3, 8'd3, "R7 upload data");
    send(7'd6, 0, 0, 8'd0, 40'd0, "R10 abort upload");
    send(7'd5, 1, 0, 8'd0, 40'd2, "R10 idle after abort");
    send(7'd65, 1, 0, 8'd0, 40'd1, "R9 block survives abort");
    send(7'd64, 0, 16'd0, 8'd0, 40'd0, "R3 select factory");
    send(7'd65, 1, 0, 8'd0, 40'd1, "R3 block survives select");
    send(7'd65, 0, 16'd5, 8'd0, 40'd0, "R9 set block");
    send(7'd65, 1, 0, 8'd0, 40'd5, "R9 read block");
    up_rlen = 40;
    send(7'd2, 1, 0, 8'd0, 40'd40, "R7 upload short");
    check("R7 requested block", 64'(fr_block), 64'd5);
    check("R3 factory image", 64'(fr_alt), 64'd0);
    send(7'd5, 1, 0, 8'd0, 40'd2, "R8 short frame ends");
    send(7'd65, 1, 0, 8'd0, 40'd0, "R8 block cleared");
    rdbuf(7'd39, 8'd119, "R7 last short byte");
    rdbuf(7'd40, 8'd0, "R7 short frame padding");
    send(7'd64, 0, 16'd2, 8'd1, 40'd0, "R3 bad image rejected");
    send(7'd4, 0, 0, 8'd0, 40'd0, "R11 clear 3");

    // reboot R2
    send(7'd0, 0, 16'h00FF, 8'd0, 40'd0, "R2 detach");
    check("R2 detach sets reboot", 64'(reboot_req), 64'd1);
    send(7'd5, 1, 0, 8'd0, 40'd2, "R2 state unchanged");
    do_reset();
    check("R2 reboot cleared by reset", 64'(reboot_req), 64'd0);
    send(7'd89, 0, 0, 8'd0, 40'd0, "R2 reboot");
    send(7'd88, 1, 0, 8'd0, 40'h0000030201, "R12 version again");
    check("R2 reboot held", 64'(reboot_req), 64'd1);

    finish_run();
  end

endmodule